// File: doc/BRIEF.md
# Bounding-Plane Depth Selector

This block settles, for one pixel of a quadric patch, which of the two surface depths survives the cuts made by the patch's bounding planes. Each cycle it takes the near and far intersection depths of the quadric, the depths of four cutting planes at the same pixel, two orientation flags per plane, and the sign of the quadric's discriminant. All four planes are tested in parallel. Each test yields a keep flag for the near depth and a keep flag for the far depth.

The keep flags are combined across the planes. They choose the surface depth passed to the normal unit. They also choose the depth written toward the Z-buffer, which is pinned to the largest positive depth when nothing is left. One register stage sits between inputs and outputs. A marker tells the normal unit when the far surface was chosen, so that it can flip the normal.

Top module: `qd_bplane_sel`

## Requirements
- R1: While rst_ni is low, and after it is released until the first accepted pixel, valid_o is 0, zout_o is 24'h7FFFFF, zsel_o is 0 and back_sel_o is 0.
- R2: A pixel presented with valid_i high at a rising edge appears on the outputs right after that edge, with valid_o high. When valid_i is low at an edge, valid_o is 0 after it and zsel_o, zout_o and back_sel_o keep their values.
- R3: When a plane's flat flag (flat_i bit k) is 1, its orientation sign bit is ignored. The plane clears both keep flags when its depth is negative, and has no effect otherwise.
- R4: A non-flat plane with facing_neg_i bit k = 1 (front-facing) clears both keep flags when its depth is greater than the far depth. Otherwise it clears only the near keep flag when its depth is greater than the near depth.
- R5: A non-flat plane with facing_neg_i bit k = 0 (back-facing) clears both keep flags when its depth is less than the near depth. Otherwise it clears only the far keep flag when its depth is less than the far depth.
- R6: Both keep flags start at 1. The final near flag is the AND of the four per-plane near results, and the same holds for the far flag. Plane k takes its depth from zp_i[24k+23:24k].
- R7: zsel_o equals the near depth when the final near flag is 1, and the far depth otherwise.
- R8: zout_o equals 24'h7FFFFF when both final flags are 0 or when disc_neg_i is 1. Otherwise it equals zsel_o.
- R9: back_sel_o is 1 exactly when the final near flag is 0 and the final far flag is 1, whatever the discriminant sign.
- R10: All depths are signed two's complement. The comparisons are exact over the full 24-bit range, including when the difference would overflow 24 bits.
- R11: All comparisons are strict: a plane depth equal to a quadric depth clears nothing through that comparison.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Pixel inputs are valid this cycle |
| zf_i | input | 24 | Near quadric depth, signed |
| zb_i | input | 24 | Far quadric depth, signed |
| zp_i | input | 96 | Four plane depths, plane k in bits 24k+23:24k, signed |
| facing_neg_i | input | 4 | Per plane: sign of the normal's z component, 1 = negative |
| flat_i | input | 4 | Per plane: normal z component is zero |
| disc_neg_i | input | 1 | Discriminant negative, no intersection at this pixel |
| valid_o | output | 1 | Outputs hold a new pixel |
| zsel_o | output | 24 | Surface depth chosen for the normal unit |
| zout_o | output | 24 | Depth toward the Z-buffer |
| back_sel_o | output | 1 | Far surface chosen, normal must be negated |

## Verification
The assertions assume that valid_i, the depths and the flags are defined at every rising edge after reset, and that the near depth is never greater than the far depth. The case analysis of the plane tests is built on that order. Every table row and directed pixel is built with zf_i at or below zb_i, and this includes the rows at the ends of the signed range and the rows with negative depths. Unused planes are parked as flat planes at depth zero, a setting the requirements define as having no effect.

// File: rtl/qd_bplane_pkg.sv
package qd_bplane_pkg;

  // per-plane survival verdict for the two quadric depths
  typedef struct packed {
    logic keep_f;
    logic keep_b;
  } cut_t;

endpackage

// File: rtl/qd_plane_cut.sv
module qd_plane_cut
  import qd_bplane_pkg::*;
#(
  parameter int DEPTH_W = 24
) (
  input  logic [DEPTH_W-1:0] zp_i,
  input  logic [DEPTH_W-1:0] zf_i,
  input  logic [DEPTH_W-1:0] zb_i,
  input  logic               facing_neg_i,
  input  logic               flat_i,
  output cut_t               cut_o
);

  localparam int DW = DEPTH_W + 1;

  logic [DW-1:0] diff_f, diff_b;
  logic          gt_f, lt_f, gt_b, lt_b;
  logic          zp_neg;

  // sign-extended by one bit so the difference cannot overflow
  assign diff_f = {zp_i[DEPTH_W-1], zp_i} - {zf_i[DEPTH_W-1], zf_i};
  assign diff_b = {zp_i[DEPTH_W-1], zp_i} - {zb_i[DEPTH_W-1], zb_i};

  assign lt_f   = diff_f[DW-1];
  assign lt_b   = diff_b[DW-1];
  assign gt_f   = !diff_f[DW-1] && (diff_f != '0);
  assign gt_b   = !diff_b[DW-1] && (diff_b != '0);
  assign zp_neg = zp_i[DEPTH_W-1];

  always_comb begin
    cut_o = '{keep_f: 1'b1, keep_b: 1'b1};
    if (flat_i) begin
      if (zp_neg) cut_o = '{keep_f: 1'b0, keep_b: 1'b0};
    end else if (facing_neg_i) begin
      if (gt_b)      cut_o = '{keep_f: 1'b0, keep_b: 1'b0};
      else if (gt_f) cut_o.keep_f = 1'b0;
    end else begin
      if (lt_f)      cut_o = '{keep_f: 1'b0, keep_b: 1'b0};
      else if (lt_b) cut_o.keep_b = 1'b0;
    end
  end

endmodule

// File: rtl/qd_cut_merge.sv
module qd_cut_merge
  import qd_bplane_pkg::*;
#(
  parameter int DEPTH_W    = 24,
  parameter int NUM_PLANES = 4
) (
  input  cut_t [NUM_PLANES-1:0] cuts_i,
  input  logic [DEPTH_W-1:0]    zf_i,
  input  logic [DEPTH_W-1:0]    zb_i,
  input  logic                  disc_neg_i,
  output logic [DEPTH_W-1:0]    zsel_o,
  output logic [DEPTH_W-1:0]    zout_o,
  output logic                  back_sel_o
);

  localparam logic [DEPTH_W-1:0] MAX_DEPTH = {1'b0, {(DEPTH_W-1){1'b1}}};

  logic [NUM_PLANES-1:0] kf_vec, kb_vec;
  logic                  ef, eb;

  for (genvar k = 0; k < NUM_PLANES; k++) begin : g_split
    assign kf_vec[k] = cuts_i[k].keep_f;
    assign kb_vec[k] = cuts_i[k].keep_b;
  end

  assign ef         = &kf_vec;
  assign eb         = &kb_vec;
  assign zsel_o     = ef ? zf_i : zb_i;
  assign zout_o     = ((!ef && !eb) || disc_neg_i) ? MAX_DEPTH : zsel_o;
  assign back_sel_o = !ef && eb;

endmodule

// File: rtl/qd_bplane_sel.sv
module qd_bplane_sel
  import qd_bplane_pkg::*;
#(
  parameter int DEPTH_W    = 24,
  parameter int NUM_PLANES = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic [DEPTH_W-1:0]            zf_i,
  input  logic [DEPTH_W-1:0]            zb_i,
  input  logic [NUM_PLANES*DEPTH_W-1:0] zp_i,
  input  logic [NUM_PLANES-1:0]         facing_neg_i,
  input  logic [NUM_PLANES-1:0]         flat_i,
  input  logic                          disc_neg_i,
  output logic                          valid_o,
  output logic [DEPTH_W-1:0]            zsel_o,
  output logic [DEPTH_W-1:0]            zout_o,
  output logic                          back_sel_o
);

  localparam logic [DEPTH_W-1:0] MAX_DEPTH = {1'b0, {(DEPTH_W-1){1'b1}}};

  cut_t [NUM_PLANES-1:0] cuts;
  logic [DEPTH_W-1:0]    zsel_d, zout_d;
  logic                  back_sel_d;

  for (genvar k = 0; k < NUM_PLANES; k++) begin : g_plane
    qd_plane_cut #(.DEPTH_W(DEPTH_W)) u_cut (
      .zp_i        (zp_i[k*DEPTH_W +: DEPTH_W]),
      .zf_i        (zf_i),
      .zb_i        (zb_i),
      .facing_neg_i(facing_neg_i[k]),
      .flat_i      (flat_i[k]),
      .cut_o       (cuts[k])
    );
  end

  qd_cut_merge #(.DEPTH_W(DEPTH_W), .NUM_PLANES(NUM_PLANES)) u_merge (
    .cuts_i    (cuts),
    .zf_i      (zf_i),
    .zb_i      (zb_i),
    .disc_neg_i(disc_neg_i),
    .zsel_o    (zsel_d),
    .zout_o    (zout_d),
    .back_sel_o(back_sel_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      zsel_o     <= '0;
      zout_o     <= MAX_DEPTH;
      back_sel_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        zsel_o     <= zsel_d;
        zout_o     <= zout_d;
        back_sel_o <= back_sel_d;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(zout_o) && $stable(zsel_o) && $stable(back_sel_o)));

  // R8
  no_hit_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && disc_neg_i) |=> (zout_o == MAX_DEPTH));

  // R7
  zsel_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (zsel_o == $past(zf_i) || zsel_o == $past(zb_i)));

  // R9
  back_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (!back_sel_o || zsel_o == $past(zb_i)));

  // R8
  zout_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (zout_o == MAX_DEPTH || zout_o == zsel_o));

endmodule

// File: tb/qd_bplane_sel_tb.sv
`timescale 1ns/1ps
module qd_bplane_sel_tb;

  localparam logic [23:0] MAXD = 24'h7FFFFF;

  typedef struct packed {
    logic [23:0] zf;
    logic [23:0] zb;
    logic [95:0] zp;
    logic [3:0]  neg;
    logic [3:0]  flat;
    logic        disc;
    logic [23:0] ex_zsel;
    logic [23:0] ex_zout;
    logic        ex_bs;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    // R7 neutral planes
    '{24'd100, 24'd200, {24'd0, 24'd0, 24'd0, 24'd0}, 4'b0000, 4'b1111, 1'b0, 24'd100, 24'd100, 1'b0, 8'd7},
    // R3 flat plane negative
    '{24'd100, 24'd200, {24'd0, 24'd0, 24'd0, 24'hFFFFFF}, 4'b0000, 4'b1111, 1'b0, 24'd200, MAXD, 1'b0, 8'd3},
    // R4 front plane beyond far depth
    '{24'd100, 24'd200, {24'd0, 24'd0, 24'd250, 24'd0}, 4'b0010, 4'b1101, 1'b0, 24'd200, MAXD, 1'b0, 8'd4},
    // R4 front plane between depths
    '{24'd100, 24'd200, {24'd0, 24'd0, 24'd150, 24'd0}, 4'b0010, 4'b1101, 1'b0, 24'd200, 24'd200, 1'b1, 8'd4},
    // R4 front plane before near depth
    '{24'd100, 24'd200, {24'd0, 24'd0, 24'd50, 24'd0}, 4'b0010, 4'b1101, 1'b0, 24'd100, 24'd100, 1'b0, 8'd4},
    // R5 back plane before near depth
    '{24'd100, 24'd200, {24'd0, 24'd50, 24'd0, 24'd0}, 4'b0000, 4'b1011, 1'b0, 24'd200, MAXD, 1'b0, 8'd5},
    // R5 back plane between depths
    '{24'd100, 24'd200, {24'd0, 24'd150, 24'd0, 24'd0}, 4'b0000, 4'b1011, 1'b0, 24'd100, 24'd100, 1'b0, 8'd5},
    // R5 back plane beyond far depth
    '{24'd100, 24'd200, {24'd0, 24'd300, 24'd0, 24'd0}, 4'b0000, 4'b1011, 1'b0, 24'd100, 24'd100, 1'b0, 8'd5},
    // R6 two partial cuts combine to nothing
    '{24'd100, 24'd200, {24'd150, 24'd0, 24'd0, 24'd150}, 4'b0001, 4'b0110, 1'b0, 24'd200, MAXD, 1'b0, 8'd6},
    // R8 discriminant negative
    '{24'd100, 24'd200, {24'd0, 24'd0, 24'd0, 24'd0}, 4'b0000, 4'b1111, 1'b1, 24'd100, MAXD, 1'b0, 8'd8},
    // R11 equal depths cut nothing
    '{24'd100, 24'd200, {24'd0, 24'd200, 24'd100, 24'd0}, 4'b0010, 4'b1001, 1'b0, 24'd100, 24'd100, 1'b0, 8'd11},
    // R10 extreme range, 24-bit difference would overflow
    '{24'h800000, 24'h7FFFFE, {24'd0, 24'd0, 24'd0, 24'h7FFFFE}, 4'b0001, 4'b1110, 1'b0, 24'h7FFFFE, 24'h7FFFFE, 1'b1, 8'd10},
    // R10 negative depths
    '{24'hFFFE0C, 24'hFFFF9C, {24'd0, 24'hFFFED4, 24'd0, 24'd0}, 4'b0000, 4'b1011, 1'b0, 24'hFFFE0C, 24'hFFFE0C, 1'b0, 8'd10},
    // R3 flat overrides orientation sign
    '{24'd0, 24'd10, {24'd0, 24'd0, 24'd5, 24'd0}, 4'b0010, 4'b1111, 1'b0, 24'd0, 24'd0, 1'b0, 8'd3},
    // R6 last plane index
    '{24'd100, 24'd200, {24'hFFFFFF, 24'd0, 24'd0, 24'd0}, 4'b0000, 4'b1111, 1'b0, 24'd200, MAXD, 1'b0, 8'd6},
    // R9 back selected even with no intersection
    '{24'd100, 24'd200, {24'd0, 24'd0, 24'd150, 24'd0}, 4'b0010, 4'b1101, 1'b1, 24'd200, MAXD, 1'b1, 8'd9}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [23:0] zf_i = '0, zb_i = '0;
  logic [95:0] zp_i = '0;
  logic [3:0]  facing_neg_i = '0, flat_i = 4'b1111;
  logic        disc_neg_i = 1'b0;
  logic        valid_o, back_sel_o;
  logic [23:0] zsel_o, zout_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk_i = ~clk_i;

  qd_bplane_sel u_dut (
    .clk_i, .rst_ni, .valid_i, .zf_i, .zb_i, .zp_i, .facing_neg_i,
    .flat_i, .disc_neg_i, .valid_o, .zsel_o, .zout_o, .back_sel_o
  );

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    zf_i = v.zf; zb_i = v.zb; zp_i = v.zp;
    facing_neg_i = v.neg; flat_i = v.flat; disc_neg_i = v.disc;
    valid_i = vld;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 24'd1, 24'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 during reset
    check("R1 valid_o in reset", {23'd0, valid_o}, 24'd0);
    check("R1 zout_o in reset", zout_o, MAXD);
    check("R1 zsel_o in reset", zsel_o, 24'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    // R1 after release, no pixel yet
    check("R1 valid_o idle", {23'd0, valid_o}, 24'd0);
    check("R1 zout_o idle", zout_o, MAXD);
    check("R1 back_sel_o idle", {23'd0, back_sel_o}, 24'd0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      drive(VECS[i], 1'b1);
      @(negedge clk_i);
      tag = $sformatf("R%0d row %0d", VECS[i].req, i);
      check({tag, " zsel"}, zsel_o, VECS[i].ex_zsel);
      check({tag, " zout"}, zout_o, VECS[i].ex_zout);
      check({tag, " back_sel"}, {23'd0, back_sel_o}, {23'd0, VECS[i].ex_bs});
      check({tag, " valid R2"}, {23'd0, valid_o}, 24'd1);
    end

    // R2 idle cycle: new inputs ignored, outputs held (last row: 200, MAX, 1)
    drive(VECS[1], 1'b0);
    @(negedge clk_i);
    check("R2 valid_o low", {23'd0, valid_o}, 24'd0);
    check("R2 zsel held", zsel_o, 24'd200);
    check("R2 zout held", zout_o, MAXD);
    check("R2 back_sel held", {23'd0, back_sel_o}, 24'd1);
    @(negedge clk_i);
    check("R2 zsel still held", zsel_o, 24'd200);

    // R2 one-cycle pulse then idle
    drive(VECS[0], 1'b1);
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R2 pulse zout", zout_o, 24'd100);
    @(negedge clk_i);
    check("R2 pulse ends", {23'd0, valid_o}, 24'd0);
    check("R2 pulse value kept", zout_o, 24'd100);

    // R1 reset mid-run
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 zout_o after reset", zout_o, MAXD);
    check("R1 zsel_o after reset", zsel_o, 24'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule